// File: doc/BRIEF.md
# Dual-Clock FIFO with Replay Marking

This block moves data words from a write clock domain to an independent read clock domain. Writes land in an inferred register array. The read side keeps a registered output word that refills by itself as soon as data is available, so the word at the output is valid whenever the output-ready flag is high. Each side has two status flags: space-available and almost-full on the write clock, and output-ready and almost-empty on the read clock. Both thresholds come from static offset inputs. Each pointer crosses domains as a Gray code through two flip-flops.

A replay mode lets a consumer read a stretch of data more than once. On entry, the word in the output register is marked and a shadow pointer records its location. While the mode holds, a replay request reloads the output register with the marked word. During the mode the write side measures its free space against the shadow pointer, so new writes can never overwrite the marked stretch.

Top module: `rtx_fifo`

## Requirements
- R1: While `rst_ni` is low, `in_rdy_o` and `out_rdy_o` and `aempty_n_o` are 0 and `afull_n_o` is 1. `in_rdy_o` is 1 within four write-clock edges after `rst_ni` rises.
- R2: Words come out of `rdata_o` in write order, with none lost and none duplicated. Each read-enabled read-clock edge while `out_rdy_o` is 1 consumes the current word. `rdata_o` and `out_rdy_o` hold while `ren_i` is low and no replay is requested.
- R3: After a word is written into an empty FIFO, `out_rdy_o` rises on the third read-clock rising edge after the write edge. The word appears on `rdata_o` at that same edge.
- R4: Read requests made while `out_rdy_o` is 0 are ignored. `rdata_o` keeps the last word and no data is skipped.
- R5: `in_rdy_o` falls on the write that stores the 2^AW-th word in the array. A word held in the output register does not occupy the array. Writes attempted while `in_rdy_o` is 0 are dropped.
- R6: `aempty_n_o` is 0 while the array holds `ae_ofs_i` or fewer words, and 1 while it holds more. The word in the output register is not counted.
- R7: `afull_n_o` is 0 while the write-side count is at least 2^AW − `af_ofs_i`, and 1 below that count.
- R8: A read-clock edge with `rtm_i` = 1 and `out_rdy_o` = 1 enters replay mode and marks the word now on `rdata_o`. Reads then continue normally. An edge with `rtm_i` = 0 leaves the mode.
- R9: In replay mode, an edge with `rfm_i` = 1 loads the marked word into `rdata_o` and sets `out_rdy_o` to 1 on that same edge. Later reads return the words that followed the marked word, in order.
- R10: A replay request is ignored until at least two reads have followed the marked word, counted since entry or since the last replay.
- R11: In replay mode, `in_rdy_o` and `afull_n_o` are computed against the marked location, so `in_rdy_o` falls once 2^AW words starting at the marked word are stored. After the mode ends, the flags follow the live read position again within a few write-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wen_i | input | 1 | Write request |
| wdata_i | input | DW | Write data |
| in_rdy_o | output | 1 | Space available (write clock) |
| afull_n_o | output | 1 | Low when almost full (write clock) |
| ren_i | input | 1 | Read request |
| rtm_i | input | 1 | Replay mode hold |
| rfm_i | input | 1 | Replay request |
| rdata_o | output | DW | Output register |
| out_rdy_o | output | 1 | Output register holds a fresh word (read clock) |
| aempty_n_o | output | 1 | Low when almost empty (read clock) |
| ae_ofs_i | input | AW | Almost-empty offset |
| af_ofs_i | input | AW | Almost-full offset |

## Verification
The read side can consume the output word and refill the output register from the array on one read-clock edge. That happens whenever a read lands while the array still holds data. The bench provokes it by reading on every cycle that `out_rdy_o` is high while words are queued behind it. The scoreboard then shows that each word appears exactly once and in write order. A second overlap is replay entry on the same edge as further reads, checked against the marked word that comes back on a later replay.

// File: rtl/rtx_fifo_pkg.sv
package rtx_fifo_pkg;
  typedef enum logic {
    RD_LIVE   = 1'b0,
    RD_MARKED = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/rtx_gray_sync.sv
module rtx_gray_sync #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_dec
    assign bin_o[i] = ^s2_q[W-1:i];
  end
endmodule

// File: rtl/rtx_mem.sv
module rtx_mem #(
  parameter int DW = 36,
  parameter int AW = 9
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rtx_wr_ctl.sv
module rtx_wr_ctl #(
  parameter int AW = 9,
  localparam int PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wen_i,
  input  logic [PW-1:0] rq_bin_i,
  input  logic [AW-1:0] ofs_y_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [PW-1:0] w_gray_o,
  output logic          in_rdy_o,
  output logic          afull_n_o
);
  localparam logic [PW-1:0] FULL_CNT = {1'b1, {AW{1'b0}}};

  logic [PW-1:0] wptr_q, wptr_nxt, used_nxt, af_lvl;
  logic          in_rdy_q, afull_n_q;

  assign we_o     = wen_i & in_rdy_q;
  assign wptr_nxt = wptr_q + {{AW{1'b0}}, we_o};
  // rq_bin_i may lag; a stale value only under-reports free space
  assign used_nxt = wptr_nxt - rq_bin_i;
  assign af_lvl   = FULL_CNT - {1'b0, ofs_y_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q    <= '0;
      w_gray_o  <= '0;
      in_rdy_q  <= 1'b0;
      afull_n_q <= 1'b1;
    end else begin
      wptr_q    <= wptr_nxt;
      w_gray_o  <= wptr_nxt ^ (wptr_nxt >> 1);
      in_rdy_q  <= used_nxt != FULL_CNT;
      afull_n_q <= used_nxt < af_lvl;
    end
  end

  assign waddr_o   = wptr_q[AW-1:0];
  assign in_rdy_o  = in_rdy_q;
  assign afull_n_o = afull_n_q;
endmodule

// File: rtl/rtx_rd_ctl.sv
module rtx_rd_ctl
  import rtx_fifo_pkg::*;
#(
  parameter int DW = 36,
  parameter int AW = 9,
  localparam int PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ren_i,
  input  logic          rtm_i,
  input  logic          rfm_i,
  input  logic [PW-1:0] wq_bin_i,
  input  logic [AW-1:0] ofs_x_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [PW-1:0] exp_gray_o,
  output logic [DW-1:0] rdata_o,
  output logic          out_rdy_o,
  output logic          aempty_n_o
);
  localparam logic [PW-1:0] P_ONE = {{AW{1'b0}}, 1'b1};

  rd_mode_e      mode_q, mode_nxt;
  logic [PW-1:0] rptr_q, rptr_nxt, shadow_q, shadow_nxt, src_ptr, exp_bin;
  logic [1:0]    since_q, since_nxt;
  logic          or_q, or_nxt, avail, rd_fire, replay, load, enter;

  assign avail    = wq_bin_i != rptr_q;
  assign rd_fire  = ren_i & or_q;
  assign replay   = (mode_q == RD_MARKED) & rtm_i & rfm_i & (since_q == 2'd2);
  assign load     = ~replay & avail & (~or_q | rd_fire);
  assign enter    = (mode_q == RD_LIVE) & rtm_i & or_q;
  assign src_ptr  = replay ? shadow_q : rptr_q;
  assign raddr_o  = src_ptr[AW-1:0];
  assign rptr_nxt = replay ? shadow_q + P_ONE : rptr_q + {{AW{1'b0}}, load};
  assign or_nxt   = replay | load | (or_q & ~rd_fire);

  always_comb begin
    mode_nxt   = mode_q;
    shadow_nxt = shadow_q;
    since_nxt  = since_q;
    if (enter) begin
      mode_nxt   = RD_MARKED;
      shadow_nxt = rptr_q - P_ONE;  // location of the word now in the output register
      since_nxt  = {1'b0, rd_fire};
    end else if (mode_q == RD_MARKED) begin
      if (!rtm_i)                          mode_nxt  = RD_LIVE;
      else if (replay)                     since_nxt = 2'd0;
      else if (rd_fire && since_q != 2'd2) since_nxt = since_q + 2'd1;
    end
  end

  // write side measures space against the mark while the mode holds
  assign exp_bin = (mode_nxt == RD_MARKED) ? shadow_nxt : rptr_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= RD_LIVE;
      rptr_q     <= '0;
      shadow_q   <= '0;
      since_q    <= '0;
      or_q       <= 1'b0;
      aempty_n_o <= 1'b0;
      exp_gray_o <= '0;
      rdata_o    <= '0;
    end else begin
      mode_q     <= mode_nxt;
      rptr_q     <= rptr_nxt;
      shadow_q   <= shadow_nxt;
      since_q    <= since_nxt;
      or_q       <= or_nxt;
      aempty_n_o <= (wq_bin_i - rptr_nxt) > {1'b0, ofs_x_i};
      exp_gray_o <= exp_bin ^ (exp_bin >> 1);
      if (load || replay) rdata_o <= mem_rdata_i;
    end
  end

  assign out_rdy_o = or_q;
endmodule

// File: rtl/rtx_fifo.sv
module rtx_fifo #(
  parameter int DW = 36,
  parameter int AW = 9
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wen_i,
  input  logic [DW-1:0] wdata_i,
  output logic          in_rdy_o,
  output logic          afull_n_o,
  input  logic          ren_i,
  input  logic          rtm_i,
  input  logic          rfm_i,
  output logic [DW-1:0] rdata_o,
  output logic          out_rdy_o,
  output logic          aempty_n_o,
  input  logic [AW-1:0] ae_ofs_i,
  input  logic [AW-1:0] af_ofs_i
);
  localparam int PW = AW + 1;

  logic [1:0]    wrst_q, rrst_q;
  logic          wrst_n, rrst_n, we;
  logic [PW-1:0] w_gray, r_gray, wq_bin, rq_bin;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] mem_rdata;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) wrst_q <= '0;
    else         wrst_q <= {wrst_q[0], 1'b1};
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) rrst_q <= '0;
    else         rrst_q <= {rrst_q[0], 1'b1};
  end

  assign wrst_n = wrst_q[1];
  assign rrst_n = rrst_q[1];

  rtx_wr_ctl #(.AW(AW)) u_wr (
    .clk_i     (wclk_i),
    .rst_ni    (wrst_n),
    .wen_i     (wen_i),
    .rq_bin_i  (rq_bin),
    .ofs_y_i   (af_ofs_i),
    .we_o      (we),
    .waddr_o   (waddr),
    .w_gray_o  (w_gray),
    .in_rdy_o  (in_rdy_o),
    .afull_n_o (afull_n_o)
  );

  rtx_gray_sync #(.W(PW)) u_r2w (
    .clk_i  (wclk_i),
    .rst_ni (wrst_n),
    .gray_i (r_gray),
    .bin_o  (rq_bin)
  );

  rtx_gray_sync #(.W(PW)) u_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rrst_n),
    .gray_i (w_gray),
    .bin_o  (wq_bin)
  );

  rtx_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk_i  (wclk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .raddr_i (raddr),
    .rdata_o (mem_rdata)
  );

  rtx_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
    .clk_i       (rclk_i),
    .rst_ni      (rrst_n),
    .ren_i       (ren_i),
    .rtm_i       (rtm_i),
    .rfm_i       (rfm_i),
    .wq_bin_i    (wq_bin),
    .ofs_x_i     (ae_ofs_i),
    .mem_rdata_i (mem_rdata),
    .raddr_o     (raddr),
    .exp_gray_o  (r_gray),
    .rdata_o     (rdata_o),
    .out_rdy_o   (out_rdy_o),
    .aempty_n_o  (aempty_n_o)
  );
endmodule

// File: rtl/rtx_fifo_chk.sv
module rtx_fifo_chk #(
  parameter int DW = 36,
  parameter int AW = 9
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          ren_i,
  input logic          rtm_i,
  input logic          rfm_i,
  input logic          in_rdy_o,
  input logic          afull_n_o,
  input logic          out_rdy_o,
  input logic          aempty_n_o,
  input logic [DW-1:0] rdata_o,
  input logic [AW:0]   w_gray
);
  AST_NO_OVERFLOW: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !in_rdy_o |=> $stable(w_gray)); // R5

  AST_FULL_IMPLIES_AFULL: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $fell(in_rdy_o) |-> !afull_n_o); // R7

  AST_EMPTY_HOLDS_DATA: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !out_rdy_o |=> (out_rdy_o || $stable(rdata_o))); // R4

  AST_IDLE_HOLDS_WORD: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (out_rdy_o && !ren_i && !(rtm_i && rfm_i)) |=> (out_rdy_o && $stable(rdata_o))); // R2

  AST_AE_NEEDS_OR: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    aempty_n_o |-> out_rdy_o); // R6
endmodule

bind rtx_fifo rtx_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
  .wclk_i     (wclk_i),
  .rclk_i     (rclk_i),
  .rst_ni     (rst_ni),
  .ren_i      (ren_i),
  .rtm_i      (rtm_i),
  .rfm_i      (rfm_i),
  .in_rdy_o   (in_rdy_o),
  .afull_n_o  (afull_n_o),
  .out_rdy_o  (out_rdy_o),
  .aempty_n_o (aempty_n_o),
  .rdata_o    (rdata_o),
  .w_gray     (w_gray)
);

// File: tb/rtx_fifo_tb.sv
module rtx_fifo_tb;
  localparam int DW = 16;
  localparam int AW = 4;

  logic          wclk = 1'b0, rclk = 1'b0, rst_ni = 1'b1;
  logic          wen = 1'b0, ren_mon = 1'b0, ren_dir = 1'b0, rtm = 1'b0, rfm = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [AW-1:0] x_ofs = AW'(3), y_ofs = AW'(4);
  logic          in_rdy, afull_n, out_rdy, aempty_n;
  logic [DW-1:0] dout;
  logic          drain = 1'b0, done = 1'b0;
  logic [DW-1:0] q[$];
  int            n_chk = 0, n_err = 0;

  rtx_fifo #(.DW(DW), .AW(AW)) u_dut (
    .wclk_i (wclk), .rclk_i (rclk), .rst_ni (rst_ni),
    .wen_i (wen), .wdata_i (wdata), .in_rdy_o (in_rdy), .afull_n_o (afull_n),
    .ren_i (ren_mon | ren_dir), .rtm_i (rtm), .rfm_i (rfm),
    .rdata_o (dout), .out_rdy_o (out_rdy), .aempty_n_o (aempty_n),
    .ae_ofs_i (x_ofs), .af_ofs_i (y_ofs)
  );

  always #4 wclk = ~wclk;
  initial begin
    #3;
    forever #4 rclk = ~rclk;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge wclk);
    wen = 1'b1;
    wdata = d;
    if (in_rdy) q.push_back(d);
    @(negedge wclk);
    wen = 1'b0;
  endtask

  task automatic rd_once();
    ren_dir = 1'b1;
    @(negedge rclk);
    ren_dir = 1'b0;
  endtask

  task automatic replay_req();
    rfm = 1'b1;
    @(negedge rclk);
    rfm = 1'b0;
  endtask

  task automatic drain_all(input string req);
    @(negedge wclk);
    drain = 1'b1;
    wait (q.size() == 0);
    repeat (6) @(negedge rclk);
    chk(!out_rdy, req, 32'(out_rdy), 0);
    @(negedge wclk);
    drain = 1'b0;
  endtask

  // monitor: consumes words while draining and compares with the scoreboard
  initial begin
    forever begin
      @(negedge rclk);
      if (drain && out_rdy) begin
        if (q.size() == 0) chk(1'b0, "R2 extra word", 32'(dout), 0);
        else begin
          chk(dout == q[0], "R2", 32'(dout), 32'(q[0]));
          q.delete(0);
        end
        ren_mon = 1'b1;
      end else begin
        ren_mon = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge wclk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge wclk);
    chk(!in_rdy && afull_n, "R1 write flags", {30'd0, in_rdy, afull_n}, 32'h1);
    chk(!out_rdy && !aempty_n, "R1 read flags", {30'd0, out_rdy, aempty_n}, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge wclk);
    chk(in_rdy, "R1 release", 32'(in_rdy), 1);

    // R3 first word fall-through timing
    wr(16'h1111);
    @(negedge rclk); chk(!out_rdy, "R3 edge1", 32'(out_rdy), 0);
    @(negedge rclk); chk(!out_rdy, "R3 edge2", 32'(out_rdy), 0);
    @(negedge rclk); chk(out_rdy && dout == 16'h1111, "R3 edge3", 32'(dout), 32'h1111);

    // R4 reads while empty are ignored
    ren_dir = 1'b1;
    repeat (5) @(negedge rclk);
    ren_dir = 1'b0;
    chk(!out_rdy && dout == 16'h1111, "R4 hold", 32'(dout), 32'h1111);
    q.delete(0);

    // R2 streaming with back-to-back consumption
    @(negedge wclk);
    drain = 1'b1;
    for (int i = 0; i < 10; i++) wr(16'h2000 + 16'(i));
    drain_all("R2 drained");

    // R6 almost-empty around X=3
    for (int i = 0; i < 4; i++) wr(16'h3000 + 16'(i));
    repeat (6) @(negedge rclk);
    chk(!aempty_n, "R6 at X", 32'(aempty_n), 0);
    wr(16'h3004);
    repeat (6) @(negedge rclk);
    chk(aempty_n, "R6 above X", 32'(aempty_n), 1);

    // R7 / R5 fill with Y=4, depth 16
    for (int i = 0; i < 7; i++) wr(16'h3005 + 16'(i));
    repeat (4) @(negedge wclk);
    chk(afull_n, "R7 below", 32'(afull_n), 1);
    wr(16'h300C);
    chk(!afull_n, "R7 at level", 32'(afull_n), 0);
    for (int i = 0; i < 3; i++) wr(16'h300D + 16'(i));
    chk(in_rdy, "R5 one free", 32'(in_rdy), 1);
    wr(16'h3010);
    chk(!in_rdy, "R5 full", 32'(in_rdy), 0);
    wr(16'hDEAD);
    wr(16'hBEEF);
    chk(!in_rdy, "R5 still full", 32'(in_rdy), 0);
    drain_all("R5 no extra words");
    repeat (6) @(negedge wclk);
    chk(in_rdy && afull_n, "R7 recovered", {30'd0, in_rdy, afull_n}, 32'h3);

    // R8-R10 replay
    for (int i = 0; i < 5; i++) wr(16'hA000 + 16'(i));
    repeat (6) @(negedge rclk);
    chk(out_rdy && dout == 16'hA000, "R8 head", 32'(dout), 32'hA000);
    rtm = 1'b1;
    @(negedge rclk);
    replay_req();
    chk(dout == 16'hA000, "R10 no reads yet", 32'(dout), 32'hA000);
    rd_once();
    chk(dout == 16'hA001, "R8 read in mode", 32'(dout), 32'hA001);
    replay_req();
    chk(dout == 16'hA001, "R10 one read", 32'(dout), 32'hA001);
    rd_once();
    chk(dout == 16'hA002, "R8 second read", 32'(dout), 32'hA002);
    replay_req();
    chk(out_rdy && dout == 16'hA000, "R9 replay", 32'(dout), 32'hA000);
    rd_once();
    chk(dout == 16'hA001, "R9 follow 1", 32'(dout), 32'hA001);
    rd_once();
    chk(dout == 16'hA002, "R9 follow 2", 32'(dout), 32'hA002);

    // R11 write-side flags measured from the mark
    for (int i = 0; i < 10; i++) wr(16'hB000 + 16'(i));
    chk(in_rdy, "R11 one left", 32'(in_rdy), 1);
    wr(16'hB00A);
    chk(!in_rdy && !afull_n, "R11 full at mark", {30'd0, in_rdy, afull_n}, 0);
    wr(16'hDEAD);
    @(negedge rclk);
    rtm = 1'b0;
    repeat (6) @(negedge wclk);
    chk(in_rdy, "R11 live after exit", 32'(in_rdy), 1);
    q.delete(0);
    q.delete(0);
    drain_all("R11 protected data");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule